// File: doc/BRIEF.md
# Event Timer Control Register Block

This block is the register front end of a multi-channel event timer. It owns the free-running 64-bit main counter, the global control word, a read-only capability word and the per-channel interrupt status bits. It also stores each channel's configuration, comparator and route words, which it hands to the channel comparator logic. That comparator logic and the interrupt delivery sit outside the block.

Software reaches the block through a 32-bit register port. Each read and each write moves one 32-bit word. A 64-bit quantity is split into two words: its lower half sits at the even word and its upper half at the word 4 bytes above. The main counter advances on a tick strobe only while the global enable bit is set. When that bit is set, each channel with a programmed comparator gets a one-cycle arm strobe. When the bit is cleared, every channel gets a one-cycle disarm strobe.

Top module: `tmr_regfile`

## Requirements
- R1: After reset the main counter is 0, the global control and status words read 0, every present channel's configuration lower word reads 0x30, its upper word reads 0x4 (only route 2 allowed), its comparator reads all ones and its route word reads 0.
- R2: Byte offset 0x000 reads {VENDOR_ID[15:0], bit15=1 (route replacement capable), bit14=0, bit13=1 (64-bit counter), channel count minus 1 in bits 12:8, revision 0x01 in bits 7:0}. Offset 0x004 reads TICK_FS. The channel count is NUM_CH clamped to the range 3 to MAX_CH.
- R3: While enabled, the main counter increments by one on each clock in which tick is high, with a full 64-bit carry.
- R4: Writes to the counter words (0x0F0 lower, 0x0F4 upper) replace that half only while the block is halted. While enabled they are ignored.
- R5: A write that changes global enable (bit 0 of offset 0x010) from 0 to 1 pulses ch_arm for one cycle, at the same edge the enable takes effect, for every channel whose comparator is not all ones.
- R6: A write that changes global enable from 1 to 0 pulses every ch_disarm bit for one cycle and freezes the counter.
- R7: Only configuration bits 1, 2, 3, 6 and 8 to 14 of a channel (mask 0x7F4E) and bits 0 to 1 of the global control word accept writes. Bits 4 and 5 of a channel configuration read 1. The upper configuration words ignore writes.
- R8: Writing a channel configuration word with bit 8 (32-bit mode) set clears the upper half of that channel's comparator.
- R9: A high ch_hit bit sets the matching status bit at offset 0x020. Writing 1 to a status bit clears it. A hit in the same cycle as its clear wins.
- R10: Channel n's window starts at 0x100 + n*0x20, with configuration at +0/+4, comparator at +8/+0xC and route at +0x10/+0x14. Offsets +0x18 and +0x1C, channels at or above the channel count, and every other undecoded offset read 0 and ignore writes.
- R11: reg_rdata presents the addressed word on the cycle after reg_rd is sampled high, and is 0 on every other cycle. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 10 | Byte address within the 1 KiB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tick | input | 1 | Counter advance strobe |
| ch_hit | input | NCH | Per-channel event from comparator logic |
| glob_enable | output | 1 | Global enable bit |
| glob_legacy | output | 1 | Route replacement bit |
| main_count | output | 64 | Main counter value |
| ch_arm | output | NCH | One-cycle arm strobes |
| ch_disarm | output | NCH | One-cycle disarm strobes |
| ch_cfg | output | NCH*32 | Channel configuration lower words |
| ch_cmp | output | NCH*64 | Channel comparators |
| ch_route | output | NCH*64 | Channel route words |

## Verification
Register writes take effect at the edge that samples reg_wr. The arm and disarm strobes, glob_enable, main_count and the channel outputs are therefore checked at the falling edge right after that write edge. Read data appears one edge after reg_rd, and the bench samples it at the following falling edge. One more falling edge later it checks that the data has returned to 0. Counter results are checked after an exact number of tick-high edges, with tick held low around every bus access. This makes the expected count plain addition from the written start value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 64;
  localparam int ADDR_W  = 10;
  localparam int MIN_CH  = 3;

  // word indexes (byte offset / 4) of the global registers
  localparam logic [7:0] W_CAP_LO  = 8'h00;
  localparam logic [7:0] W_CAP_HI  = 8'h01;
  localparam logic [7:0] W_GCFG    = 8'h04;
  localparam logic [7:0] W_STAT    = 8'h08;
  localparam logic [7:0] W_CNT_LO  = 8'h3C;
  localparam logic [7:0] W_CNT_HI  = 8'h3D;

  localparam logic [31:0] CFG_WR_MASK  = 32'h0000_7F4E;
  localparam logic [31:0] CFG_RO_BITS  = 32'h0000_0030;
  localparam logic [31:0] CFG_HI_VALUE = 32'h0000_0004;
  localparam int          CFG_W32_BIT  = 8;
  localparam logic [1:0]  GCFG_WR_MASK = 2'b11;

  typedef enum logic [2:0] {
    F_CFG_LO = 3'd0,
    F_CFG_HI = 3'd1,
    F_CMP_LO = 3'd2,
    F_CMP_HI = 3'd3,
    F_RTE_LO = 3'd4,
    F_RTE_HI = 3'd5,
    F_GAP_A  = 3'd6,
    F_GAP_B  = 3'd7
  } chan_fld_e;

  function automatic logic [31:0] cap_low(input logic [15:0] vendor, input int nch);
    logic [4:0] cnt_m1;
    cnt_m1 = 5'(nch - 1);
    return {vendor, 1'b1, 1'b0, 1'b1, cnt_m1, 8'h01};
  endfunction
endpackage

// File: rtl/tmr_main_counter.sv
module tmr_main_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (run) begin
      if (tick) count <= count + 1'b1;
    end else begin
      if (wr_lo) count[31:0]       <= wdata;
      if (wr_hi) count[CNT_W-1:32] <= wdata;
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic        cmp_wr_lo,
  input  logic        cmp_wr_hi,
  input  logic        rte_wr_lo,
  input  logic        rte_wr_hi,
  input  logic [31:0] wdata,
  output logic [31:0] cfg,
  output logic [63:0] cmp,
  output logic [63:0] route
);
  logic [31:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cmp   <= '1;
      route <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_q <= (cfg_q & ~CFG_WR_MASK) | (wdata & CFG_WR_MASK);
        if (wdata[CFG_W32_BIT]) cmp[63:32] <= '0;
      end
      if (cmp_wr_lo) cmp[31:0]    <= wdata;
      if (cmp_wr_hi) cmp[63:32]   <= wdata;
      if (rte_wr_lo) route[31:0]  <= wdata;
      if (rte_wr_hi) route[63:32] <= wdata;
    end
  end

  assign cfg = cfg_q | CFG_RO_BITS;
endmodule

// File: rtl/tmr_glob_regs.sv
module tmr_glob_regs
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic           stat_wr,
  input  logic [31:0]    wdata,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] armable,
  output logic           enable,
  output logic           legacy,
  output logic [NCH-1:0] status,
  output logic [NCH-1:0] arm,
  output logic [NCH-1:0] disarm
);
  logic [1:0]     next_cfg;
  logic [NCH-1:0] clr_mask;

  assign next_cfg = wdata[1:0] & GCFG_WR_MASK;
  assign clr_mask = stat_wr ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      legacy <= 1'b0;
      status <= '0;
      arm    <= '0;
      disarm <= '0;
    end else begin
      arm    <= '0;
      disarm <= '0;
      if (cfg_wr) begin
        enable <= next_cfg[0];
        legacy <= next_cfg[1];
        if (next_cfg[0] && !enable) arm    <= armable;
        if (!next_cfg[0] && enable) disarm <= '1;
      end
      status <= (status & ~clr_mask) | hit;
    end
  end
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int          NUM_CH    = 4,
  parameter int          MAX_CH    = 8,
  parameter logic [31:0] TICK_FS   = 32'd10_000_000,
  parameter logic [15:0] VENDOR_ID = 16'hB00C,
  localparam int         NCH = (NUM_CH < MIN_CH) ? MIN_CH :
                               ((NUM_CH > MAX_CH) ? MAX_CH : NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tick,
  input  logic [NCH-1:0]    ch_hit,
  output logic              glob_enable,
  output logic              glob_legacy,
  output logic [CNT_W-1:0]  main_count,
  output logic [NCH-1:0]    ch_arm,
  output logic [NCH-1:0]    ch_disarm,
  output logic [NCH*32-1:0] ch_cfg,
  output logic [NCH*64-1:0] ch_cmp,
  output logic [NCH*64-1:0] ch_route
);
  localparam logic [31:0] CAP_LO = cap_low(VENDOR_ID, NCH);

  // ---------------- address decode ----------------
  logic [7:0]     word;
  logic           in_chan;
  logic [4:0]     ch_idx;
  chan_fld_e      fld;
  logic           wr_gcfg, wr_stat, wr_cnt_lo, wr_cnt_hi;
  logic [NCH-1:0] status;
  logic [NCH-1:0] armable;
  logic [31:0]    rd_val;

  assign word    = reg_addr[ADDR_W-1:2];
  assign in_chan = (reg_addr[ADDR_W-1:8] != '0);
  assign ch_idx  = reg_addr[ADDR_W-1:5] - 5'd8;
  assign fld     = chan_fld_e'(reg_addr[4:2]);

  assign wr_gcfg   = reg_wr && !in_chan && (word == W_GCFG);
  assign wr_stat   = reg_wr && !in_chan && (word == W_STAT);
  assign wr_cnt_lo = reg_wr && !in_chan && (word == W_CNT_LO);
  assign wr_cnt_hi = reg_wr && !in_chan && (word == W_CNT_HI);

  // ---------------- main counter ----------------
  tmr_main_counter u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (glob_enable),
    .tick  (tick),
    .wr_lo (wr_cnt_lo),
    .wr_hi (wr_cnt_hi),
    .wdata (reg_wdata),
    .count (main_count)
  );

  // ---------------- global control and status ----------------
  tmr_glob_regs #(.NCH(NCH)) u_glob (
    .clk     (clk),
    .rst     (rst),
    .cfg_wr  (wr_gcfg),
    .stat_wr (wr_stat),
    .wdata   (reg_wdata),
    .hit     (ch_hit),
    .armable (armable),
    .enable  (glob_enable),
    .legacy  (glob_legacy),
    .status  (status),
    .arm     (ch_arm),
    .disarm  (ch_disarm)
  );

  // ---------------- channel windows ----------------
  logic [31:0] cfg_a [NCH];
  logic [63:0] cmp_a [NCH];
  logic [63:0] rte_a [NCH];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel;
    assign sel = reg_wr && in_chan && (ch_idx == 5'(n));

    tmr_chan_regs u_regs (
      .clk       (clk),
      .rst       (rst),
      .cfg_wr    (sel && (fld == F_CFG_LO)),
      .cmp_wr_lo (sel && (fld == F_CMP_LO)),
      .cmp_wr_hi (sel && (fld == F_CMP_HI)),
      .rte_wr_lo (sel && (fld == F_RTE_LO)),
      .rte_wr_hi (sel && (fld == F_RTE_HI)),
      .wdata     (reg_wdata),
      .cfg       (cfg_a[n]),
      .cmp       (cmp_a[n]),
      .route     (rte_a[n])
    );

    assign armable[n]          = (cmp_a[n] != '1);
    assign ch_cfg[n*32 +: 32]  = cfg_a[n];
    assign ch_cmp[n*64 +: 64]  = cmp_a[n];
    assign ch_route[n*64 +: 64] = rte_a[n];
  end

  // ---------------- read mux ----------------
  always_comb begin
    rd_val = '0;
    if (in_chan) begin
      for (int n = 0; n < NCH; n++) begin
        if (ch_idx == 5'(n)) begin
          case (fld)
            F_CFG_LO: rd_val = cfg_a[n];
            F_CFG_HI: rd_val = CFG_HI_VALUE;
            F_CMP_LO: rd_val = cmp_a[n][31:0];
            F_CMP_HI: rd_val = cmp_a[n][63:32];
            F_RTE_LO: rd_val = rte_a[n][31:0];
            F_RTE_HI: rd_val = rte_a[n][63:32];
            default:  rd_val = '0;
          endcase
        end
      end
    end else begin
      case (word)
        W_CAP_LO: rd_val = CAP_LO;
        W_CAP_HI: rd_val = TICK_FS;
        W_GCFG:   rd_val = {30'd0, glob_legacy, glob_enable};
        W_STAT:   rd_val = 32'(status);
        W_CNT_LO: rd_val = main_count[31:0];
        W_CNT_HI: rd_val = main_count[63:32];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_rd ? rd_val : '0;
  end
endmodule

// File: rtl/tmr_regfile_chk.sv
module tmr_regfile_chk
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              tick,
  input logic              glob_enable,
  input logic [CNT_W-1:0]  main_count,
  input logic [NCH-1:0]    ch_arm,
  input logic [NCH-1:0]    ch_disarm
);
  logic cnt_wr;
  assign cnt_wr = reg_wr && (reg_addr[ADDR_W-1:3] == 7'h1E);

  // R3: counting while enabled
  p_run_count_r3: assert property (@(posedge clk) disable iff (rst)
    (glob_enable && tick) |=> (main_count == $past(main_count) + 1'b1));

  // R4: no tick while enabled -> counter holds, writes included
  p_run_wr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (glob_enable && !tick) |=> $stable(main_count));

  // R6: halted and not written -> counter frozen
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!glob_enable && !cnt_wr) |=> $stable(main_count));

  // R5: arm strobes only alongside enable and last one cycle
  p_arm_with_enable_r5: assert property (@(posedge clk) disable iff (rst)
    (ch_arm != '0) |-> glob_enable);
  p_arm_single_r5: assert property (@(posedge clk) disable iff (rst)
    (ch_arm != '0) |=> (ch_arm == '0));

  // R6: falling enable disarms all
  p_disarm_all_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(glob_enable) |-> (ch_disarm == '1));

  // R10: gap fields in a channel window read zero
  p_gap_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr[ADDR_W-1:8] != '0) && (reg_addr[4:3] == 2'b11))
    |=> (reg_rdata == '0));

  // R11: no read -> zero data
  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));
endmodule

bind tmr_regfile tmr_regfile_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .tick        (tick),
  .glob_enable (glob_enable),
  .main_count  (main_count),
  .ch_arm      (ch_arm),
  .ch_disarm   (ch_disarm)
);

// File: tb/tmr_regfile_tb.sv
module tmr_regfile_tb;
  localparam int          NCH     = 4;
  localparam logic [31:0] TICK    = 32'd10_000_000;
  localparam logic [15:0] VEND    = 16'hB00C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, tick = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_c;
  logic [NCH-1:0] ch_hit = '0;
  logic           glob_enable, glob_legacy;
  logic [63:0]    main_count;
  logic [NCH-1:0] ch_arm, ch_disarm;
  logic [NCH*32-1:0] ch_cfg;
  logic [NCH*64-1:0] ch_cmp, ch_route;

  logic        c_en, c_leg;
  logic [63:0] c_cnt;
  logic [2:0]  c_arm, c_dis;
  logic [95:0] c_cfg;
  logic [191:0] c_cmp, c_rte;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_regfile #(.NUM_CH(NCH), .TICK_FS(TICK), .VENDOR_ID(VEND)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .tick(tick), .ch_hit(ch_hit),
    .glob_enable(glob_enable), .glob_legacy(glob_legacy), .main_count(main_count),
    .ch_arm(ch_arm), .ch_disarm(ch_disarm), .ch_cfg(ch_cfg), .ch_cmp(ch_cmp),
    .ch_route(ch_route));

  tmr_regfile #(.NUM_CH(1), .TICK_FS(TICK), .VENDOR_ID(VEND)) u_clamp (
    .clk(clk), .rst(rst), .reg_wr(1'b0), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_c), .tick(1'b0), .ch_hit(3'b000),
    .glob_enable(c_en), .glob_legacy(c_leg), .main_count(c_cnt),
    .ch_arm(c_arm), .ch_disarm(c_dis), .ch_cfg(c_cfg), .ch_cmp(c_cmp),
    .ch_route(c_rte));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d, output logic [31:0] dc);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = rdata; dc = rdata_c;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] cap_lo(input int nch);
    return {VEND, 16'h0000} | 32'h8000 | 32'h2000 | (32'(nch - 1) << 8) | 32'h1;
  endfunction

  function automatic logic [31:0] pat(input int w);
    return 32'h5A00_00A5 | (32'((w >> 3) - 8) << 16) | (32'(w & 7) << 12);
  endfunction

  // expected value of word w, after reset (swept=0) or after pattern sweep (swept=1)
  function automatic logic [31:0] exp_word(input int w, input bit swept);
    int ch, f;
    if (w == 0) return cap_lo(NCH);
    if (w == 1) return TICK;
    if (w < 'h40) return 32'h0;
    ch = (w >> 3) - 8; f = w & 7;
    if (ch >= NCH) return 32'h0;
    case (f)
      0: return swept ? (32'h30 | (pat(w) & 32'h7F4E)) : 32'h30;
      1: return 32'h4;
      2, 3: return swept ? pat(w) : 32'hFFFF_FFFF;
      4, 5: return swept ? pat(w) : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, dc;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1, R2, R10: full sweep of reset values
    chk("R1 counter", main_count, 64'h0);
    chk("R1 enable", {63'h0, glob_enable}, 64'h0);
    for (int w = 0; w < 256; w++) begin
      bus_rd(10'(w << 2), d, dc);
      chk($sformatf("R1/R10 reset word %0h", w), {32'h0, d}, {32'h0, exp_word(w, 0)});
    end
    bus_rd(10'h000, d, dc);
    chk("R2 capability low", {32'h0, d}, {32'h0, cap_lo(NCH)});
    chk("R2 clamp to minimum", {32'h0, dc}, {32'h0, cap_lo(3)});
    bus_rd(10'h006, d, dc);
    chk("R11 low address bits ignored", {32'h0, d}, {32'h0, TICK});
    @(negedge clk);
    chk("R11 rdata back to zero", {32'h0, rdata}, 64'h0);

    // R7, R10: pattern sweep over every channel window word
    for (int w = 'h40; w < 256; w++) bus_wr(10'(w << 2), pat(w));
    for (int w = 0; w < 256; w++) begin
      bus_rd(10'(w << 2), d, dc);
      chk($sformatf("R7/R10 swept word %0h", w), {32'h0, d}, {32'h0, exp_word(w, 1)});
    end
    chk("R10 comparator port ch3", ch_cmp[3*64 +: 64], {pat('h5B), pat('h5A)});
    chk("R10 route port ch2", ch_route[2*64 +: 64], {pat('h55), pat('h54)});
    chk("R7 config port ch1", {32'h0, ch_cfg[32 +: 32]}, 64'h34);

    // R8: 32-bit mode clears comparator upper half
    bus_wr(10'h120, 32'h0000_0100);
    bus_rd(10'h12C, d, dc);
    chk("R8 comparator high cleared", {32'h0, d}, 64'h0);
    bus_rd(10'h128, d, dc);
    chk("R8 comparator low kept", {32'h0, d}, {32'h0, pat('h4A)});
    bus_rd(10'h120, d, dc);
    chk("R7 config ro bits kept", {32'h0, d}, 64'h130);

    // R5, R3, R4, R6
    do_reset();
    bus_wr(10'h148, 32'h77);
    bus_wr(10'h0F0, 32'hFFFF_FFFE);
    bus_wr(10'h0F4, 32'h1);
    chk("R4 counter written while halted", main_count, 64'h1_FFFF_FFFE);
    bus_wr(10'h010, 32'h1);
    chk("R5 arm mask", {60'h0, ch_arm}, 64'h4);
    chk("R5 enable set", {63'h0, glob_enable}, 64'h1);
    @(negedge clk);
    chk("R5 arm single cycle", {60'h0, ch_arm}, 64'h0);
    tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    chk("R3 count with carry", main_count, 64'h2_0000_0003);
    bus_wr(10'h0F0, 32'h0);
    bus_wr(10'h0F4, 32'h0);
    bus_rd(10'h0F0, d, dc);
    chk("R4 write ignored low", {32'h0, d}, 64'h3);
    bus_rd(10'h0F4, d, dc);
    chk("R4 write ignored high", {32'h0, d}, 64'h2);
    bus_wr(10'h010, 32'hFFFF_FFFE);
    chk("R6 disarm all", {60'h0, ch_disarm}, 64'hF);
    chk("R7 legacy bit", {63'h0, glob_legacy}, 64'h1);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    chk("R6 frozen", main_count, 64'h2_0000_0003);
    bus_rd(10'h010, d, dc);
    chk("R7 global config mask", {32'h0, d}, 64'h2);
    bus_wr(10'h0F0, 32'h11);
    bus_wr(10'h0F4, 32'h22);
    chk("R4 halted write halves", main_count, 64'h22_0000_0011);

    // R9: status set / clear / priority
    @(negedge clk); ch_hit = 4'b1010;
    @(negedge clk); ch_hit = 4'b0000;
    bus_rd(10'h020, d, dc);
    chk("R9 status set", {32'h0, d}, 64'hA);
    bus_wr(10'h020, 32'h2);
    bus_rd(10'h020, d, dc);
    chk("R9 write one clears", {32'h0, d}, 64'h8);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 10'h020; reg_wdata = 32'h8; ch_hit = 4'b1000;
    @(negedge clk);
    reg_wr = 1'b0; ch_hit = 4'b0000;
    bus_rd(10'h020, d, dc);
    chk("R9 hit wins over clear", {32'h0, d}, 64'h8);
    bus_wr(10'h020, 32'h8);
    bus_rd(10'h020, d, dc);
    chk("R9 cleared", {32'h0, d}, 64'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule